// File: doc/BRIEF.md
# Prescaled Reloadable Watchdog Counter

This block guards a small processor against a stalled program. A free-running prescaler divides the system clock by a fixed terminal count, and every prescaler tick moves an 8-bit counter one step up. Software loads a start value into a reload register and must keep restarting the counter from that value. If the counter climbs to its top before software does so, the block raises a sticky status flag. When the reset-enable bit is set, it also sends a fixed-width reset request to the chip's reset logic.

Software reaches the block through a small register port with three addresses: control, reload, and a read-only view of the live count. An idle input freezes both the prescaler and the counter. The synchronous active-low reset clears everything, including the status flag. The block's own reset request does not clear the flag, so software can tell after restart that the watchdog caused the reset.

Top module: `tick_watchdog`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, prescaler, reload value, enable bits, status flag and reset request all return to zero. Reads then give 0 at every address.
- R2: With run set and idle low, the counter advances once every `PRESCALE` clock cycles. Overflow fires on the (255 − reload)-th tick after a refresh, so `(255 − reload) × PRESCALE` cycles after the refresh edge. Reload values 254 and 255 both overflow on the first tick.
- R3: The register map is as follows. Address 0 is control: bit 0 refresh (write 1, always reads 0), bit 1 run, bit 2 reset enable, bit 3 status flag. Address 1 is the reload value (read and write). Address 2 is the live count (read only). Read data is combinational from `reg_addr`.
- R4: A refresh loads the count from the reload value and clears the prescaler on the same edge. A refresh on the edge where overflow would occur wins, and no overflow happens.
- R5: Overflow sets the status flag on the overflow edge. The flag stays set through the reset request and the counter reload that follow.
- R6: Writing control with bit 3 at 1 clears the flag. Writing control with bit 3 at 0 leaves the flag unchanged. A new overflow on the same edge as a clear wins.
- R7: With reset enable at 1, overflow drives `wdt_rst_req` high for exactly `PULSE_LEN` cycles, starting on the overflow edge. With reset enable at 0, overflow never raises it.
- R8: On overflow the counter reloads from the reload value.
- R9: While `idle` is high, the counter and the prescaler hold their values. Counting resumes from the held state when `idle` falls.
- R10: While run is 0, the counter holds its value and no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low external or power-on reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 reload, 2 count) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| idle | input | 1 | Processor idle condition; freezes the watchdog |
| wdt_rst_req | output | 1 | Internal reset request pulse |
| wdt_flag | output | 1 | Sticky overflow status flag |

## Verification
The bench checks the timeout length exactly for reload values spread from 0 to 255. This includes the 254 and 255 endpoints, where an off-by-one or a missing clamp would make the block overflow one tick late or after a full 256-tick wrap. It times a refresh onto the very edge of overflow, which catches a design that lets the overflow win and fires a spurious reset. It freezes the count with idle and then times the rest of the timeout after idle falls, which exposes a prescaler that keeps running or restarts. It also checks that a zero in bit 3 does not clear the flag, that the flag outlives the reset pulse, and that the pulse width is exact.

// File: rtl/wdg_pkg.sv
// Package: shared register map for the watchdog.
// Assumes an 8-bit register port with three word addresses.
package wdg_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_RELOAD = 2'd1,
        ADDR_COUNT  = 2'd2
    } wdg_addr_e;

    localparam int DATA_W      = 8;
    localparam int BIT_REFRESH = 0;
    localparam int BIT_RUN     = 1;
    localparam int BIT_RST_EN  = 2;
    localparam int BIT_FLAG    = 3;

endpackage

// File: rtl/wdg_prescaler.sv
// Module: wdg_prescaler
// Divides the system clock by PRESCALE and emits one tick per period.
// Holds while 'active' is low. 'clear' restarts the period from zero
// and wins over counting. Assumes PRESCALE >= 2.
module wdg_prescaler #(
    parameter int PRESCALE = 344064
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic clear,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] TERM = PW'(PRESCALE - 1);

    logic [PW-1:0] cnt;

    assign tick = active && !clear && (cnt == TERM);

    // Purpose: advance the divider, wrap at terminal count, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (active) begin
            cnt <= (cnt == TERM) ? '0 : cnt + 1'b1;
        end
    end

    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TERM); // R2
    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !clear) |=> $stable(cnt)); // R9
endmodule

// File: rtl/wdg_counter.sv
// Module: wdg_counter
// The watchdog count itself. It loads the reload value on refresh and
// steps up by one on each tick. When a tick arrives at the top (or one
// below), it reports overflow and reloads. Refresh wins over a tick.
module wdg_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         refresh,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] LAST = {{(W-1){1'b1}}, 1'b0};

    assign ovf = tick && !refresh && (count >= LAST);

    // Purpose: load, step, or reload the watchdog count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (refresh) begin
            count <= reload;
        end else if (ovf) begin
            count <= reload;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    AST_REFRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (count == $past(reload))); // R4
    AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (count == $past(reload))); // R8
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !refresh) |=> $stable(count)); // R9
endmodule

// File: rtl/wdg_pulse.sv
// Module: wdg_pulse
// Stretches a one-cycle start strobe into a request exactly LEN cycles
// wide. A start during an active pulse restarts the full width.
module wdg_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic req
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] remain;

    assign req = (remain != '0);

    // Purpose: load the width on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(LEN);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> req); // R7
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= CW'(LEN)); // R7
endmodule

// File: rtl/wdg_regs.sv
// Module: wdg_regs
// Software-visible registers: the control bits, the reload value and
// the sticky flag. Refresh is a pulse decoded from the write and is
// never stored. Overflow setting the flag wins over a write-one clear.
module wdg_regs
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count,
    input  logic              flag_set,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] reload,
    output logic              run,
    output logic              rst_en,
    output logic              refresh,
    output logic              flag
);
    logic ctrl_wr;
    logic reload_wr;
    logic flag_clr;

    assign ctrl_wr   = wr && (addr == ADDR_CTRL);
    assign reload_wr = wr && (addr == ADDR_RELOAD);
    assign refresh   = ctrl_wr && wdata[BIT_REFRESH];
    assign flag_clr  = ctrl_wr && wdata[BIT_FLAG];

    // Purpose: store the run and reset-enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            rst_en <= 1'b0;
        end else if (ctrl_wr) begin
            run    <= wdata[BIT_RUN];
            rst_en <= wdata[BIT_RST_EN];
        end
    end

    // Purpose: store the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (reload_wr) begin
            reload <= wdata;
        end
    end

    // Purpose: sticky flag, set by overflow, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (flag_set) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    // Purpose: select read data by address.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: begin
                rdata[BIT_RUN]    = run;
                rdata[BIT_RST_EN] = rst_en;
                rdata[BIT_FLAG]   = flag;
            end
            ADDR_RELOAD: rdata = reload;
            ADDR_COUNT:  rdata = count;
            default:     rdata = '0;
        endcase
    end

    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag); // R5
    AST_FLAG_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ctrl_wr && !wdata[BIT_FLAG]) |=> flag); // R6
endmodule

// File: rtl/tick_watchdog.sv
// Module: tick_watchdog (top)
// Prescaled watchdog. It joins the register file, the prescaler, the
// 8-bit counter and the reset pulse stretcher. The counter runs while
// run is set and idle is low. Overflow sets the flag and, when enabled,
// requests a reset of PULSE_LEN cycles.
module tick_watchdog #(
    parameter int PRESCALE  = 344064,
    parameter int PULSE_LEN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       idle,
    output logic       wdt_rst_req,
    output logic       wdt_flag
);
    import wdg_pkg::*;

    logic [DATA_W-1:0] reload;
    logic [DATA_W-1:0] count;
    logic              run;
    logic              rst_en;
    logic              refresh;
    logic              tick;
    logic              ovf;
    logic              active;

    assign active = run && !idle;

    wdg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .count    (count),
        .flag_set (ovf),
        .rdata    (reg_rdata),
        .reload   (reload),
        .run      (run),
        .rst_en   (rst_en),
        .refresh  (refresh),
        .flag     (wdt_flag)
    );

    wdg_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .clear  (refresh || !run),
        .tick   (tick)
    );

    wdg_counter #(.W(DATA_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .refresh (refresh),
        .tick    (tick),
        .reload  (reload),
        .count   (count),
        .ovf     (ovf)
    );

    wdg_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ovf && rst_en),
        .req   (wdt_rst_req)
    );

    AST_FLAG_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> wdt_flag); // R5
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_req) |-> $past(rst_en)); // R7
    AST_NO_OVF_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !ovf); // R10
endmodule

// File: tb/tick_watchdog_test.sv
module tick_watchdog_test;
    localparam int P   = 4;
    localparam int LEN = 16;

    // Each entry: reload value [23:16], expected cycles to overflow [15:0].
    localparam logic [23:0] VECS [0:5] = '{
        24'hFA_0014, 24'hC8_00DC, 24'hFF_0004,
        24'h00_03FC, 24'h80_01FC, 24'hFE_0004
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       idle = 1'b0;
    logic       wdt_rst_req;
    logic       wdt_flag;

    int checks = 0;
    int errors = 0;

    tick_watchdog #(.PRESCALE(P), .PULSE_LEN(LEN)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle(idle),
        .wdt_rst_req(wdt_rst_req), .wdt_flag(wdt_flag)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; write lands on the next posedge; returns at a negedge.
    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
        reg_addr = 2'd0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (!wdt_flag && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    int v, n, w;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 flag", int'(wdt_flag), 0);
        check("R1 req", int'(wdt_rst_req), 0);
        rd_reg(2'd0, v); check("R1 ctrl", v, 0);
        rd_reg(2'd2, v); check("R1 count", v, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: register map read-back
        wr_reg(2'd1, 8'h5A);
        rd_reg(2'd1, v); check("R3 reload", v, 8'h5A);
        wr_reg(2'd0, 8'h07);
        rd_reg(2'd0, v); check("R3 ctrl refresh reads 0", v, 8'h06);
        wr_reg(2'd0, 8'h0C);

        // R2: table of reload values and timeouts
        for (int i = 0; i < 6; i++) begin
            wr_reg(2'd1, VECS[i][23:16]);
            wr_reg(2'd0, 8'h07);
            measure(n);
            check("R2 timeout", n, int'(VECS[i][15:0]));
            check("R7 req with flag", int'(wdt_rst_req), 1);
            rd_reg(2'd2, v); check("R8 reload after overflow", v, int'(VECS[i][23:16]));
            if (i == 0) begin
                w = 1;
                while (wdt_rst_req && w < 100) begin
                    @(negedge clk);
                    if (wdt_rst_req) w++;
                end
                check("R7 pulse width", w, LEN);
                check("R5 flag survives request", int'(wdt_flag), 1);
            end
            wr_reg(2'd0, 8'h0C);
            check("R6 write-one clears", int'(wdt_flag), 0);
        end

        // R6: writing zero to the flag bit keeps it
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd0, 8'h07);
        measure(n);
        wr_reg(2'd0, 8'h04);
        check("R6 zero write keeps flag", int'(wdt_flag), 1);
        wr_reg(2'd0, 8'h0C);
        check("R6 one write clears", int'(wdt_flag), 0);
        repeat (20) @(negedge clk);

        // R7: reset enable off gives no request
        wr_reg(2'd1, 8'd250);
        wr_reg(2'd0, 8'h03);
        w = 0;
        n = 0;
        while (!wdt_flag && n < 5000) begin
            @(negedge clk);
            n++;
            if (wdt_rst_req) w++;
        end
        check("R7 timeout without enable", n, 20);
        repeat (5) @(negedge clk);
        if (wdt_rst_req) w++;
        check("R7 no request when disabled", w, 0);
        wr_reg(2'd0, 8'h0C);

        // R9: idle freezes the count and the prescaler
        wr_reg(2'd1, 8'd10);
        wr_reg(2'd0, 8'h07);
        repeat (2 * P) @(negedge clk);
        rd_reg(2'd2, v); check("R2 count after two ticks", v, 12);
        idle = 1'b1;
        repeat (20) @(negedge clk);
        rd_reg(2'd2, v); check("R9 count held in idle", v, 12);
        idle = 1'b0;
        measure(n);
        check("R9 resume timing", n, 243 * P);
        wr_reg(2'd0, 8'h0C);

        // R10: run off holds the count
        wr_reg(2'd1, 8'd100);
        wr_reg(2'd0, 8'h07);
        repeat (2 * P) @(negedge clk);
        wr_reg(2'd0, 8'h04);
        repeat (20) @(negedge clk);
        rd_reg(2'd2, v); check("R10 count held when stopped", v, 102);
        check("R10 no overflow when stopped", int'(wdt_flag), 0);

        // R4: refresh on the overflow edge wins
        wr_reg(2'd1, 8'd250);
        wr_reg(2'd0, 8'h07);
        repeat (5 * P - 1) @(negedge clk);
        wr_reg(2'd0, 8'h07);
        check("R4 collision no flag", int'(wdt_flag), 0);
        check("R4 collision no request", int'(wdt_rst_req), 0);
        rd_reg(2'd2, v); check("R4 collision reloads", v, 250);

        // R4: periodic refresh keeps the watchdog quiet
        w = 0;
        for (int k = 0; k < 10; k++) begin
            repeat (12) @(negedge clk);
            if (wdt_flag || wdt_rst_req) w++;
            wr_reg(2'd0, 8'h07);
        end
        check("R4 periodic refresh", w, 0);
        wr_reg(2'd0, 8'h0C);

        // R1: external reset clears a set flag
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd0, 8'h07);
        measure(n);
        check("R5 flag set before reset", int'(wdt_flag), 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset clears flag", int'(wdt_flag), 0);
        check("R1 reset clears request", int'(wdt_rst_req), 0);
        rd_reg(2'd0, v); check("R1 reset clears ctrl", v, 0);
        rd_reg(2'd1, v); check("R1 reset clears reload", v, 0);
        rd_reg(2'd2, v); check("R1 reset clears count", v, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule